// File: doc/BRIEF.md
# Test Access Port with Gated In-System Programming

This block is the serial test and configuration port of a reprogrammable logic device. Four pins, a test clock, a mode select, a serial input and a serial output, drive the usual sixteen-state test access state machine. Behind it sit a 4-bit instruction register, a one-stage bypass path, a 32-bit identification register and a shift register for in-system programming. There is no test-reset pin. The device's power-up reset input forces the machine into its reset state. Holding mode select high for five clocks does the same.

Four private opcodes drive a row-oriented nonvolatile array port. One opcode arms the programming path. The other three issue a whole-array erase, program the addressed row from the shift register, or read the addressed row back into the shift register. The erase, program and read operations take effect only while the arming latch is set. The latch stays set across later instructions. It is cleared by power-up reset and by any visit to the reset state. The array itself and its pulse timing are outside this block. It sees only single-cycle strobes, a row address, write data and the row data returned.

Top module: `isp_tap_ctrl`

## Requirements
- R1: While `por_n` is low, the port is in its reset state. The instruction is IDCODE, the arming latch is clear, all three array strobes are low and `tdo` is high-impedance. Once `por_n` returns high, a data scan returns the identification value.
- R2: `tms` and `tdi` are sampled on the rising edge of `tck` and step the standard sixteen-state machine. Five consecutive high `tms` samples reach the reset state from any state. A data scan may pass through Pause-DR and resume without losing bits.
- R3: `tdo` changes only on the falling edge of `tck` and shifts the least significant bit first. It is driven only in Shift-IR and Shift-DR, and is high-impedance in every other state.
- R4: The instruction register is 4 bits wide. Capture-IR loads 4'b0001, so an instruction scan shifts out 1, 0, 0, 0. The new instruction applies at Update-IR. Every cycle spent in the reset state loads IDCODE.
- R5: Opcode 4'b0001 (IDCODE) places a 32-bit register between `tdi` and `tdo`. Capture-DR loads the parameter `ID_VALUE` into it.
- R6: Opcode 4'b1111 (BYPASS) and every opcode not listed in R5 or R7 select a one-stage bypass register. It captures 0 and delays `tdi` by one shift. An instruction scan with `tdi` held high therefore selects bypass.
- R7: Opcodes 4'b1001 (arm), 4'b1010 (erase), 4'b1011 (program) and 4'b1100 (read) select the programming register, which is `ADDR_W+DATA_W` bits wide. Its low `DATA_W` bits drive `nv_wdata` and its upper `ADDR_W` bits drive `nv_addr`.
- R8: Update-IR of the arm opcode sets the arming latch. The latch stays set through later instructions and is cleared by `por_n` low or by the reset state. Without it, no array strobe is issued.
- R9: With the latch set, `nv_erase` (erase opcode) or `nv_prog` (program opcode) is high for exactly one cycle, the first cycle in Run-Test/Idle after entering it.
- R10: With the latch set and the read opcode active, `nv_verify` is high during Capture-DR and the data field loads `nv_rdata`, while the address field is kept. Without the latch, there is no strobe and the register keeps its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Power-up reset, active low, asynchronous |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in, sampled on rising `tck` |
| tdo | output | 1 | Serial data out, updated on falling `tck`, high-impedance outside shift states |
| nv_addr | output | ADDR_W | Row address from the programming register |
| nv_wdata | output | DATA_W | Row write data from the programming register |
| nv_rdata | input | DATA_W | Row read data for the addressed row |
| nv_erase | output | 1 | Single-cycle whole-array erase strobe |
| nv_prog | output | 1 | Single-cycle row program strobe |
| nv_verify | output | 1 | Row read strobe, high during Capture-DR |

## Verification
Instruction scans with all-ones, unused and all-zero codes separate the bypass fallback from the identification and programming registers. A scan through Pause-DR shows that the state machine holds its shift position while `tdo` is released. Each erase, program and read sequence runs twice, once before and once after the arm opcode, so a gating defect shows up as a strobe count or captured-data mismatch. A reset by five high `tms` clocks and a mid-scan power-up reset both check that the arming latch is cleared and that IDCODE is reloaded.

// File: rtl/isp_tap_pkg.sv
package isp_tap_pkg;

  localparam int IR_W = 4;
  localparam int ID_W = 32;

  typedef enum logic [3:0] {
    TS_RESET, TS_IDLE,
    TS_SEL_DR, TS_CAP_DR, TS_SHIFT_DR, TS_EXIT1_DR, TS_PAUSE_DR, TS_EXIT2_DR, TS_UPD_DR,
    TS_SEL_IR, TS_CAP_IR, TS_SHIFT_IR, TS_EXIT1_IR, TS_PAUSE_IR, TS_EXIT2_IR, TS_UPD_IR
  } tap_state_e;

  typedef enum logic [1:0] {DR_BYPASS, DR_IDCODE, DR_ISP} dr_sel_e;

  localparam logic [IR_W-1:0] OP_IDCODE     = 4'b0001;
  localparam logic [IR_W-1:0] OP_BYPASS     = 4'b1111;
  localparam logic [IR_W-1:0] OP_ISP_ARM    = 4'b1001;
  localparam logic [IR_W-1:0] OP_ISP_ERASE  = 4'b1010;
  localparam logic [IR_W-1:0] OP_ISP_PROG   = 4'b1011;
  localparam logic [IR_W-1:0] OP_ISP_VERIFY = 4'b1100;
  localparam logic [IR_W-1:0] IR_CAPTURE    = 4'b0001;

  function automatic tap_state_e tap_next(input tap_state_e s, input logic tms);
    tap_state_e n;
    case (s)
      TS_RESET:    n = tms ? TS_RESET    : TS_IDLE;
      TS_IDLE:     n = tms ? TS_SEL_DR   : TS_IDLE;
      TS_SEL_DR:   n = tms ? TS_SEL_IR   : TS_CAP_DR;
      TS_CAP_DR:   n = tms ? TS_EXIT1_DR : TS_SHIFT_DR;
      TS_SHIFT_DR: n = tms ? TS_EXIT1_DR : TS_SHIFT_DR;
      TS_EXIT1_DR: n = tms ? TS_UPD_DR   : TS_PAUSE_DR;
      TS_PAUSE_DR: n = tms ? TS_EXIT2_DR : TS_PAUSE_DR;
      TS_EXIT2_DR: n = tms ? TS_UPD_DR   : TS_SHIFT_DR;
      TS_UPD_DR:   n = tms ? TS_SEL_DR   : TS_IDLE;
      TS_SEL_IR:   n = tms ? TS_RESET    : TS_CAP_IR;
      TS_CAP_IR:   n = tms ? TS_EXIT1_IR : TS_SHIFT_IR;
      TS_SHIFT_IR: n = tms ? TS_EXIT1_IR : TS_SHIFT_IR;
      TS_EXIT1_IR: n = tms ? TS_UPD_IR   : TS_PAUSE_IR;
      TS_PAUSE_IR: n = tms ? TS_EXIT2_IR : TS_PAUSE_IR;
      TS_EXIT2_IR: n = tms ? TS_UPD_IR   : TS_SHIFT_IR;
      TS_UPD_IR:   n = tms ? TS_SEL_DR   : TS_IDLE;
      default:     n = TS_RESET;
    endcase
    return n;
  endfunction

  function automatic dr_sel_e decode_dr(input logic [IR_W-1:0] op);
    dr_sel_e d;
    case (op)
      OP_IDCODE:                                             d = DR_IDCODE;
      OP_ISP_ARM, OP_ISP_ERASE, OP_ISP_PROG, OP_ISP_VERIFY: d = DR_ISP;
      default:                                               d = DR_BYPASS;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import isp_tap_pkg::*;
(
  input  logic       tck,
  input  logic       por_n,
  input  logic       tms,
  output tap_state_e state_q,
  output tap_state_e state_nx
);

  assign state_nx = tap_next(state_q, tms);

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) state_q <= TS_RESET;
    else        state_q <= state_nx;
  end

  AST_SHIFT_EXIT: assert property (@(posedge tck) disable iff (!por_n)
    (state_q == TS_SHIFT_DR && tms) |=> (state_q == TS_EXIT1_DR)); // R2
  AST_RESET_HOLD: assert property (@(posedge tck) disable iff (!por_n)
    (state_q == TS_RESET && tms) |=> (state_q == TS_RESET)); // R2

endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import isp_tap_pkg::*;
(
  input  logic            tck,
  input  logic            por_n,
  input  tap_state_e      state_q,
  input  logic            tdi,
  output logic [IR_W-1:0] ir_q,
  output logic [IR_W-1:0] ir_sr_q
);

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) begin
      ir_q    <= OP_IDCODE;
      ir_sr_q <= IR_CAPTURE;
    end else begin
      case (state_q)
        TS_RESET:    ir_q    <= OP_IDCODE;
        TS_CAP_IR:   ir_sr_q <= IR_CAPTURE;
        TS_SHIFT_IR: ir_sr_q <= {tdi, ir_sr_q[IR_W-1:1]};
        TS_UPD_IR:   ir_q    <= ir_sr_q;
        default: ;
      endcase
    end
  end

  AST_IR_RESET_ID: assert property (@(posedge tck) disable iff (!por_n)
    (state_q == TS_RESET) |=> (ir_q == OP_IDCODE)); // R4
  AST_IR_CAPTURE: assert property (@(posedge tck) disable iff (!por_n)
    (state_q == TS_CAP_IR) |=> (ir_sr_q == IR_CAPTURE)); // R4
  AST_IR_STABLE: assert property (@(posedge tck) disable iff (!por_n)
    (state_q != TS_UPD_IR && state_q != TS_RESET) |=> $stable(ir_q)); // R4

endmodule

// File: rtl/isp_dr.sv
module isp_dr
  import isp_tap_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              tck,
  input  logic              por_n,
  input  tap_state_e        state_q,
  input  tap_state_e        state_nx,
  input  logic [IR_W-1:0]   ir_q,
  input  logic              isp_sel,
  input  logic              tdi,
  input  logic [DATA_W-1:0] nv_rdata,
  output logic              sr_lsb,
  output logic [ADDR_W-1:0] nv_addr,
  output logic [DATA_W-1:0] nv_wdata,
  output logic              nv_erase,
  output logic              nv_prog,
  output logic              nv_verify
);

  localparam int SR_W = ADDR_W + DATA_W;

  logic [SR_W-1:0] sr_q;
  logic            armed_q;
  logic            idle_entry_q;
  logic            idle_first;

  assign nv_addr  = sr_q[SR_W-1:DATA_W];
  assign nv_wdata = sr_q[DATA_W-1:0];
  assign sr_lsb   = sr_q[0];

  // first cycle in Run-Test/Idle after arriving from another state
  assign idle_first = idle_entry_q && (state_q == TS_IDLE);
  assign nv_erase   = armed_q && idle_first && (ir_q == OP_ISP_ERASE);
  assign nv_prog    = armed_q && idle_first && (ir_q == OP_ISP_PROG);
  assign nv_verify  = armed_q && (state_q == TS_CAP_DR) && (ir_q == OP_ISP_VERIFY);

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) begin
      armed_q      <= 1'b0;
      idle_entry_q <= 1'b0;
    end else begin
      idle_entry_q <= (state_q != TS_IDLE) && (state_nx == TS_IDLE);
      if (state_q == TS_RESET)        armed_q <= 1'b0;
      else if (ir_q == OP_ISP_ARM)    armed_q <= 1'b1;
    end
  end

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) begin
      sr_q <= '0;
    end else if (isp_sel) begin
      if (nv_verify)                    sr_q <= {sr_q[SR_W-1:DATA_W], nv_rdata};
      else if (state_q == TS_SHIFT_DR)  sr_q <= {tdi, sr_q[SR_W-1:1]};
    end
  end

  AST_STROBE_ARMED: assert property (@(posedge tck) disable iff (!por_n)
    (nv_erase || nv_prog || nv_verify) |-> armed_q); // R8
  AST_STROBE_ONEHOT: assert property (@(posedge tck) disable iff (!por_n)
    $onehot0({nv_erase, nv_prog, nv_verify})); // R9
  AST_ERASE_PULSE: assert property (@(posedge tck) disable iff (!por_n)
    nv_erase |=> !nv_erase); // R9
  AST_PROG_PULSE: assert property (@(posedge tck) disable iff (!por_n)
    nv_prog |=> !nv_prog); // R9
  AST_ARM_CLEAR: assert property (@(posedge tck) disable iff (!por_n)
    (state_q == TS_RESET) |=> !armed_q); // R8
  AST_VERIFY_ADDR_KEPT: assert property (@(posedge tck) disable iff (!por_n)
    nv_verify |=> $stable(nv_addr)); // R10

endmodule

// File: rtl/isp_tap_ctrl.sv
module isp_tap_ctrl
  import isp_tap_pkg::*;
#(
  parameter int           ADDR_W   = 8,
  parameter int           DATA_W   = 16,
  parameter logic [31:0]  ID_VALUE = 32'h2A6B_C0D3
) (
  input  logic              tck,
  input  logic              por_n,
  input  logic              tms,
  input  logic              tdi,
  output logic              tdo,
  output logic [ADDR_W-1:0] nv_addr,
  output logic [DATA_W-1:0] nv_wdata,
  input  logic [DATA_W-1:0] nv_rdata,
  output logic              nv_erase,
  output logic              nv_prog,
  output logic              nv_verify
);

  tap_state_e      state_q;
  tap_state_e      state_nx;
  logic [IR_W-1:0] ir_q;
  logic [IR_W-1:0] ir_sr_q;
  dr_sel_e         dr_sel;
  logic            bypass_q;
  logic [ID_W-1:0] id_sr_q;
  logic            isp_lsb;
  logic            in_shift;
  logic            dr_lsb;
  logic            tdo_q;
  logic            tdo_oe_q;

  tap_fsm u_fsm (
    .tck      (tck),
    .por_n    (por_n),
    .tms      (tms),
    .state_q  (state_q),
    .state_nx (state_nx)
  );

  tap_ir u_ir (
    .tck     (tck),
    .por_n   (por_n),
    .state_q (state_q),
    .tdi     (tdi),
    .ir_q    (ir_q),
    .ir_sr_q (ir_sr_q)
  );

  assign dr_sel = decode_dr(ir_q);

  isp_dr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_isp (
    .tck       (tck),
    .por_n     (por_n),
    .state_q   (state_q),
    .state_nx  (state_nx),
    .ir_q      (ir_q),
    .isp_sel   (dr_sel == DR_ISP),
    .tdi       (tdi),
    .nv_rdata  (nv_rdata),
    .sr_lsb    (isp_lsb),
    .nv_addr   (nv_addr),
    .nv_wdata  (nv_wdata),
    .nv_erase  (nv_erase),
    .nv_prog   (nv_prog),
    .nv_verify (nv_verify)
  );

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) begin
      bypass_q <= 1'b0;
      id_sr_q  <= ID_VALUE;
    end else if (state_q == TS_CAP_DR) begin
      if (dr_sel == DR_BYPASS) bypass_q <= 1'b0;
      if (dr_sel == DR_IDCODE) id_sr_q  <= ID_VALUE;
    end else if (state_q == TS_SHIFT_DR) begin
      if (dr_sel == DR_BYPASS) bypass_q <= tdi;
      if (dr_sel == DR_IDCODE) id_sr_q  <= {tdi, id_sr_q[ID_W-1:1]};
    end
  end

  always_comb begin
    case (dr_sel)
      DR_IDCODE: dr_lsb = id_sr_q[0];
      DR_ISP:    dr_lsb = isp_lsb;
      default:   dr_lsb = bypass_q;
    endcase
  end

  assign in_shift = (state_q == TS_SHIFT_IR) || (state_q == TS_SHIFT_DR);

  always_ff @(negedge tck or negedge por_n) begin
    if (!por_n) begin
      tdo_q    <= 1'b0;
      tdo_oe_q <= 1'b0;
    end else begin
      tdo_oe_q <= in_shift;
      tdo_q    <= (state_q == TS_SHIFT_IR) ? ir_sr_q[0] : dr_lsb;
    end
  end

  assign tdo = tdo_oe_q ? tdo_q : 1'bz;

  AST_TDO_RELEASED: assert property (@(posedge tck) disable iff (!por_n)
    !in_shift |-> !tdo_oe_q); // R3
  AST_BYPASS_CAPTURE: assert property (@(posedge tck) disable iff (!por_n)
    (state_q == TS_CAP_DR && dr_sel == DR_BYPASS) |=> !bypass_q); // R6
  AST_ID_CAPTURE: assert property (@(posedge tck) disable iff (!por_n)
    (state_q == TS_CAP_DR && dr_sel == DR_IDCODE) |=> (id_sr_q == ID_VALUE)); // R5

endmodule

// File: tb/isp_tap_ctrl_tb.sv
`timescale 1ns/1ps
module isp_tap_ctrl_tb;

  localparam logic [31:0] ID = 32'h2A6B_C0D3;

  logic        tck = 1'b0;
  logic        por_n = 1'b0;
  logic        tms = 1'b1;
  logic        tdi = 1'b0;
  wire         tdo;
  logic [7:0]  nv_addr;
  logic [15:0] nv_wdata;
  logic [15:0] nv_rdata;
  logic        nv_erase, nv_prog, nv_verify;

  int checks = 0;
  int errors = 0;
  int n_erase = 0, n_prog = 0, n_verify = 0;
  logic [7:0]  p_addr;
  logic [15:0] p_data;
  bit done = 0;

  always #5 tck = ~tck;

  function automatic logic [15:0] row_of(input logic [7:0] a);
    return {a ^ 8'h5A, ~a};
  endfunction
  assign nv_rdata = row_of(nv_addr);

  isp_tap_ctrl u_dut (
    .tck(tck), .por_n(por_n), .tms(tms), .tdi(tdi), .tdo(tdo),
    .nv_addr(nv_addr), .nv_wdata(nv_wdata), .nv_rdata(nv_rdata),
    .nv_erase(nv_erase), .nv_prog(nv_prog), .nv_verify(nv_verify)
  );

  always @(posedge tck) begin
    if (nv_erase) n_erase++;
    if (nv_verify) n_verify++;
    if (nv_prog) begin n_prog++; p_addr = nv_addr; p_data = nv_wdata; end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d);
    tms = m; tdi = d;
    @(posedge tck); @(negedge tck); #1;
  endtask

  task automatic shift_bits(input int n, input logic [63:0] din, output logic [63:0] dout);
    dout = '0;
    for (int i = 0; i < n; i++) begin
      dout[i] = tdo;
      step(i == n - 1, din[i]);
    end
  endtask

  // from Run-Test/Idle; ends in Run-Test/Idle or Select-DR-Scan
  task automatic ir_scan(input logic [3:0] op, input logic go_dr);
    logic [63:0] cap;
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    shift_bits(4, {60'd0, op}, cap);
    chk("R4 ir capture", cap[3:0], 4'b0001);
    step(1, 0);
    step(go_dr, 0);
  endtask

  task automatic dr_scan(input logic from_sel, input int n, input logic [63:0] din,
                         output logic [63:0] dout);
    if (!from_sel) step(1, 0);
    step(0, 0); step(0, 0);
    shift_bits(n, din, dout);
    step(1, 0); step(0, 0);
  endtask

  task automatic t_reset;
    logic [63:0] d;
    repeat (3) @(negedge tck);
    #1;
    chk("R1 tdo z in reset", {63'd0, tdo}, {63'd0, 1'bz});
    chk("R1 strobes low", {61'd0, nv_erase, nv_prog, nv_verify}, 64'd0);
    por_n = 1'b1;
    step(0, 0);
    chk("R3 tdo z in idle", {63'd0, tdo}, {63'd0, 1'bz});
    dr_scan(0, 32, 64'd0, d);
    chk("R1 R5 idcode after power-up", d, {32'd0, ID});
  endtask

  task automatic t_bypass(input logic [3:0] op, input string tag);
    logic [63:0] d;
    logic [7:0] pat;
    pat = 8'b1011_0010;
    ir_scan(op, 0);
    dr_scan(0, 8, {56'd0, pat}, d);
    chk(tag, d[7:0], {pat[6:0], 1'b0});
  endtask

  task automatic t_idcode_pause;
    logic [63:0] lo, hi;
    ir_scan(4'b0001, 0);
    step(1, 0); step(0, 0); step(0, 0);
    shift_bits(16, 64'd0, lo);
    step(0, 0);
    chk("R3 tdo z in pause", {63'd0, tdo}, {63'd0, 1'bz});
    step(1, 0); step(0, 0);
    shift_bits(16, 64'd0, hi);
    step(1, 0); step(0, 0);
    chk("R2 R5 idcode through pause", {32'd0, hi[15:0], lo[15:0]}, {32'd0, ID});
  endtask

  task automatic t_unarmed;
    logic [63:0] d;
    int e0, p0, v0;
    e0 = n_erase; p0 = n_prog; v0 = n_verify;
    ir_scan(4'b1010, 0);
    step(0, 0); step(0, 0);
    chk("R8 no erase unarmed", n_erase - e0, 0);
    ir_scan(4'b1011, 1);
    dr_scan(1, 24, {40'd0, 8'h44, 16'h5555}, d);
    chk("R8 no program unarmed", n_prog - p0, 0);
    ir_scan(4'b1100, 0);
    dr_scan(0, 24, {40'd0, 8'h77, 16'h1234}, d);
    chk("R10 unarmed verify keeps content", d[23:0], {8'h44, 16'h5555});
    dr_scan(0, 24, 64'd0, d);
    chk("R10 unarmed second scan", d[23:0], {8'h77, 16'h1234});
    chk("R10 no verify strobe unarmed", n_verify - v0, 0);
  endtask

  task automatic t_armed;
    logic [63:0] d;
    int e0, p0, v0;
    ir_scan(4'b1001, 0);
    e0 = n_erase;
    ir_scan(4'b1010, 0);
    step(0, 0); step(0, 0); step(0, 0);
    chk("R9 single erase strobe", n_erase - e0, 1);
    p0 = n_prog;
    ir_scan(4'b1011, 1);
    dr_scan(1, 24, {40'd0, 8'h3C, 16'hBEEF}, d);
    step(0, 0);
    chk("R9 single program strobe", n_prog - p0, 1);
    chk("R7 program address", {56'd0, p_addr}, {56'd0, 8'h3C});
    chk("R7 program data", {48'd0, p_data}, {48'd0, 16'hBEEF});
    v0 = n_verify;
    ir_scan(4'b1100, 0);
    dr_scan(0, 24, {40'd0, 8'h11, 16'h0000}, d);
    chk("R10 verify loads addressed row", d[23:0], {8'h3C, row_of(8'h3C)});
    dr_scan(0, 24, 64'd0, d);
    chk("R10 verify second row", d[23:0], {8'h11, row_of(8'h11)});
    chk("R10 verify strobes", n_verify - v0, 2);
  endtask

  task automatic t_tms_reset;
    logic [63:0] d;
    int e0;
    repeat (5) step(1, 0);
    step(0, 0);
    dr_scan(0, 32, 64'd0, d);
    chk("R4 idcode reloaded by reset state", d, {32'd0, ID});
    e0 = n_erase;
    ir_scan(4'b1010, 0);
    step(0, 0);
    chk("R8 arm cleared by reset state", n_erase - e0, 0);
  endtask

  task automatic t_por_mid;
    logic [63:0] d;
    int e0;
    ir_scan(4'b1001, 0);
    ir_scan(4'b1111, 0);
    step(1, 0); step(0, 0); step(0, 0);
    step(0, 1);
    por_n = 1'b0;
    #1;
    chk("R1 tdo z on power-up reset", {63'd0, tdo}, {63'd0, 1'bz});
    @(negedge tck); #1;
    por_n = 1'b1;
    step(0, 0);
    dr_scan(0, 32, 64'd0, d);
    chk("R1 idcode after mid-scan reset", d, {32'd0, ID});
    e0 = n_erase;
    ir_scan(4'b1010, 0);
    step(0, 0);
    chk("R1 arm cleared by power-up reset", n_erase - e0, 0);
  endtask

  initial begin
    t_reset();
    t_bypass(4'b1111, "R6 bypass opcode");
    t_bypass(4'b0110, "R6 unknown opcode");
    t_bypass(4'b0000, "R6 zero opcode");
    t_idcode_pause();
    t_unarmed();
    t_armed();
    t_tms_reset();
    t_por_mid();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge tck);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule